// File: doc/BRIEF.md
# Segmented Cubic Activation Evaluator

This block approximates a nonlinear activation curve with a table of sixteen segments. Each segment holds four polynomial coefficients and a start point. An incoming signed Q8.8 operand picks its segment. The block then subtracts that segment's start point and evaluates a polynomial of degree up to three in the offset. It uses a pipelined Horner chain of multiply-add stages. The result is rounded once at the end and clipped to the Q8.8 range.

The host fills the table at run time through a write port and holds no built-in curve. A `busy` output reports whether any operand is still in flight. Table writes take effect only while `busy` is low, so results in flight always see one consistent table. Operands stream in with a valid/ready handshake, and results stream out the same way. The whole pipeline stalls while a finished result waits on the output.

Top module: `cubic_seg_eval`

## Requirements
- R1: After reset `out_valid` and `busy` are low, `in_ready` is high, and every stored table value is zero, so any operand evaluates to 0.
- R2: A write with `cfg_we` high stores `cfg_data` into segment `cfg_seg`. The field is chosen by `cfg_fld`: 0 = constant term, 1 = linear, 2 = square, 3 = cube, 4 = start point. Codes 5 to 7 change nothing.
- R3: A write presented while `busy` is high is dropped, and the table keeps its previous contents.
- R4: `in_ready` is low in any cycle where `cfg_we` is high, and in any cycle where a result is held on the output.
- R5: The chosen segment is the highest-numbered one whose start point is less than or equal to the operand. When no start point is at or below the operand, segment 0 is used.
- R6: With t = x − start point (Q8.8), the result equals c0 + c1·t + c2·t² + c3·t³. The sum is computed without intermediate loss and rounded once to Q8.8, with ties toward positive infinity.
- R7: Results above 32767 give 32767, and results below −32768 give −32768.
- R8: When the output is never stalled, a result appears exactly five clock edges after its operand is accepted. One operand can be accepted per cycle, and results leave in arrival order.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_y` does not change.
- R10: `busy` is high from the edge after an operand is accepted until the edge on which the last result in flight is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_seg | input | 4 | Segment to write |
| cfg_fld | input | 3 | Field code to write (see R2) |
| cfg_data | input | 16 | Signed Q8.8 value to store |
| busy | output | 1 | Operands are in flight; table writes are dropped |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_x | input | 16 | Signed Q8.8 operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_y | output | 16 | Signed Q8.8 result |

## Verification
The bench targets operands that sit exactly on a start point, one LSB below it, and below the first segment. A design with an off-by-one compare picks the wrong segment there, and a probe table with a distinct constant per segment exposes it directly. Random cubic tables are compared against a polynomial sum that is rounded only once, which catches a design that drops the square or cube term, rounds between stages, or truncates its accumulator. Segments loaded with extreme coefficients drive both ends of the output range, where a wrap instead of a clip flips the sign. A write slipped in while operands are in flight must leave later results unchanged. Random output stalls must hold data steady and lose nothing.

// File: rtl/cseval_pkg.sv
package cseval_pkg;

   // Field codes of the table write port
   typedef enum logic [2:0] {
      FLD_C0  = 3'd0,
      FLD_C1  = 3'd1,
      FLD_C2  = 3'd2,
      FLD_C3  = 3'd3,
      FLD_BRK = 3'd4
   } coef_fld_e;

   localparam int COEF_N = 4;

   // Accumulator width that holds a cubic in an offset of dw+1 bits exactly
   function automatic int horner_acc_w(input int dw);
      return dw + 3 * (dw + 1) + 2;
   endfunction

endpackage

// File: rtl/cseval_coef_bank.sv
module cseval_coef_bank
   import cseval_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SEG_N  = 16,
   parameter int SEG_W  = $clog2(SEG_N)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEG_W-1:0]         wr_seg,
   input  logic [2:0]               wr_fld,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     busy,
   output logic signed [DATA_W-1:0] coef_tbl [SEG_N][COEF_N],
   output logic signed [DATA_W-1:0] brk_tbl  [SEG_N]
);

   localparam int ENT_N = COEF_N + 1;

   logic [SEG_N-1:0][ENT_N-1:0][DATA_W-1:0] mem;
   logic                                    wr_ok;

   assign wr_ok = wr_en && !busy && (wr_fld <= 3'(FLD_BRK));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (wr_ok) begin
         mem[wr_seg][wr_fld] <= wr_data;
      end
   end

   for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      for (genvar k = 0; k < COEF_N; k++) begin : g_coef
         assign coef_tbl[s][k] = mem[s][k];
      end
      assign brk_tbl[s] = mem[s][COEF_N];
   end

   // R3
   locked_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem));

endmodule

// File: rtl/cseval_seg_search.sv
module cseval_seg_search #(
   parameter int DATA_W = 16,
   parameter int SEG_N  = 16,
   parameter int SEG_W  = $clog2(SEG_N)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [DATA_W-1:0] brk_tbl [SEG_N],
   output logic [SEG_W-1:0]         sel
);

   // Highest-numbered start point at or below x wins; none gives 0
   always_comb begin
      sel = '0;
      for (int i = 0; i < SEG_N; i++) begin
         if (x >= brk_tbl[i]) sel = SEG_W'(i);
      end
   end

   logic [SEG_W-1:0] sel_nxt;
   assign sel_nxt = sel + 1'b1;

   // R5
   seg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != '0) |-> (x >= brk_tbl[sel]));

   // R5
   seg_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != SEG_W'(SEG_N - 1)) |-> (x < brk_tbl[sel_nxt]));

endmodule

// File: rtl/cseval_horner_stage.sv
module cseval_horner_stage #(
   parameter int DATA_W = 16,
   parameter int T_W    = 17,
   parameter int ACC_W  = 69,
   parameter int SHIFT  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     adv,
   input  logic                     vld_in,
   input  logic signed [T_W-1:0]    t_in,
   input  logic signed [ACC_W-1:0]  acc_in,
   input  logic signed [DATA_W-1:0] coef,
   output logic                     vld_out,
   output logic signed [ACC_W-1:0] acc_out
);

   logic signed [ACC_W-1:0] prod;
   logic signed [ACC_W-1:0] cext;
   logic signed [ACC_W-1:0] nxt;

   assign prod = acc_in * ACC_W'(t_in);
   assign cext = ACC_W'(coef);
   assign nxt  = prod + (cext <<< SHIFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_out <= 1'b0;
         acc_out <= '0;
      end else if (adv) begin
         vld_out <= vld_in;
         acc_out <= nxt;
      end
   end

endmodule

// File: rtl/cubic_seg_eval.sv
module cubic_seg_eval
   import cseval_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int FRAC_W = 8,
   parameter int SEG_N  = 16,
   parameter int SEG_W  = $clog2(SEG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic [2:0]        cfg_fld,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              busy,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_x,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_y
);

   localparam int T_W    = DATA_W + 1;
   localparam int ACC_W  = horner_acc_w(DATA_W);
   localparam int STG_N  = COEF_N - 1;
   localparam int RND_SH = STG_N * FRAC_W;

   localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (RND_SH - 1);
   localparam logic signed [ACC_W-1:0] Y_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] Y_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   if (SEG_N < 2 || (1 << SEG_W) != SEG_N) begin : g_bad_seg
      $error("SEG_N must be a power of two of at least 2");
   end
   if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_bad_frac
      $error("FRAC_W must lie between 1 and DATA_W-1");
   end

   // Table and segment lookup
   logic signed [DATA_W-1:0] coef_tbl [SEG_N][COEF_N];
   logic signed [DATA_W-1:0] brk_tbl  [SEG_N];
   logic signed [DATA_W-1:0] xs;
   logic [SEG_W-1:0]         sel;

   assign xs = in_x;

   cseval_coef_bank #(.DATA_W(DATA_W), .SEG_N(SEG_N), .SEG_W(SEG_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_seg   (cfg_seg),
      .wr_fld   (cfg_fld),
      .wr_data  (cfg_data),
      .busy     (busy),
      .coef_tbl (coef_tbl),
      .brk_tbl  (brk_tbl)
   );

   cseval_seg_search #(.DATA_W(DATA_W), .SEG_N(SEG_N), .SEG_W(SEG_W)) i_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .x       (xs),
      .brk_tbl (brk_tbl),
      .sel     (sel)
   );

   // Flow control: one global advance, stalled by a held result
   logic adv;
   logic out_vld;
   logic accept;

   assign adv      = !(out_vld && !out_ready);
   assign in_ready = adv && !cfg_we;
   assign accept   = in_valid && in_ready;

   // Offset and segment index travel beside the accumulator
   logic                    s0_vld;
   logic signed [T_W-1:0]   tp [STG_N];
   logic [SEG_W-1:0]        ip [STG_N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s0_vld <= 1'b0;
         for (int k = 0; k < STG_N; k++) begin
            tp[k] <= '0;
            ip[k] <= '0;
         end
      end else if (adv) begin
         s0_vld <= accept;
         tp[0]  <= T_W'(xs) - T_W'(brk_tbl[sel]);
         ip[0]  <= sel;
         for (int k = 1; k < STG_N; k++) begin
            tp[k] <= tp[k-1];
            ip[k] <= ip[k-1];
         end
      end
   end

   // Horner chain: cube term seeds, then square, linear, constant
   logic                    hv   [STG_N];
   logic signed [ACC_W-1:0] hacc [STG_N];

   for (genvar j = 0; j < STG_N; j++) begin : g_stage
      logic                     v_in;
      logic signed [ACC_W-1:0]  a_in;
      logic signed [DATA_W-1:0] cf;

      if (j == 0) begin : g_seed
         assign v_in = s0_vld;
         assign a_in = ACC_W'(coef_tbl[ip[0]][COEF_N-1]);
      end else begin : g_link
         assign v_in = hv[j-1];
         assign a_in = hacc[j-1];
      end
      assign cf = coef_tbl[ip[j]][STG_N-1-j];

      cseval_horner_stage #(
         .DATA_W (DATA_W),
         .T_W    (T_W),
         .ACC_W  (ACC_W),
         .SHIFT  ((j + 1) * FRAC_W)
      ) i_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv     (adv),
         .vld_in  (v_in),
         .t_in    (tp[j]),
         .acc_in  (a_in),
         .coef    (cf),
         .vld_out (hv[j]),
         .acc_out (hacc[j])
      );
   end

   // Single rounding step and clip
   logic signed [ACC_W-1:0] rnd;
   logic signed [ACC_W-1:0] rsh;
   logic [DATA_W-1:0]       y_nxt;

   assign rnd = hacc[STG_N-1] + HALF;
   assign rsh = rnd >>> RND_SH;

   always_comb begin
      if (rsh > Y_MAX)      y_nxt = Y_MAX[DATA_W-1:0];
      else if (rsh < Y_MIN) y_nxt = Y_MIN[DATA_W-1:0];
      else                  y_nxt = rsh[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_y   <= '0;
      end else if (adv) begin
         out_vld <= hv[STG_N-1];
         out_y   <= y_nxt;
      end
   end

   assign out_valid = out_vld;

   always_comb begin
      busy = s0_vld | out_vld;
      for (int k = 0; k < STG_N; k++) busy = busy | hv[k];
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);

   // R10
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(out_valid && out_ready));

endmodule

// File: tb/test_cubic_seg_eval.sv
`timescale 1ns/100ps
module test_cubic_seg_eval;

   localparam int DW = 16;
   localparam int SN = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_seg = '0;
   logic [2:0]    cfg_fld = '0;
   logic [DW-1:0] cfg_data = '0;
   logic          busy;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_x = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_y;

   always #2 clk = ~clk;

   cubic_seg_eval #(.DATA_W(DW), .FRAC_W(8), .SEG_N(SN)) i_cubic_seg_eval (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
      .cfg_fld(cfg_fld), .cfg_data(cfg_data), .busy(busy),
      .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x),
      .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y)
   );

   // Reference table as the host believes it
   int mc [SN][4];
   int mbp [SN];
   int exp_q [$];
   int cyc_q [$];
   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int last_y = 0;
   bit lat_en = 1'b0;
   bit last_acc = 1'b0;
   bit prev_stall = 1'b0;
   int prev_y = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ref_seg(input int x);
      int s = 0;
      for (int i = 0; i < SN; i++) if (x >= mbp[i]) s = i;
      return s;
   endfunction

   function automatic int ref_eval(input int x);
      int s;
      logic signed [127:0] t, v, r;
      s = ref_seg(x);
      t = 128'(x - mbp[s]);
      v = (128'(mc[s][0]) <<< 24) + 128'(mc[s][1]) * t * 128'sd65536
        + 128'(mc[s][2]) * t * t * 128'sd256 + 128'(mc[s][3]) * t * t * t;
      r = (v + (128'sd1 <<< 23)) >>> 24;
      if (r > 128'sd32767) return 32767;
      if (r < -128'sd32768) return -32768;
      return int'(r);
   endfunction

   // Observe just before each rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         cyc++;
         if (prev_stall) begin
            chk("R9 valid held", int'(out_valid), 1);
            chk("R9 data held", int'($signed(out_y)), prev_y);
         end
         if (out_valid && out_ready) begin
            last_y = int'($signed(out_y));
            if (exp_q.size() == 0) chk("R8 extra result", 1, 0);
            else begin
               int e, c;
               e = exp_q.pop_front();
               c = cyc_q.pop_front();
               chk("R6 result", last_y, e);
               if (lat_en) chk("R8 latency", cyc - c, 5);
            end
         end
         if (cfg_we) chk("R4 input blocked by write", int'(in_ready), 0);
         if (in_valid && in_ready) begin
            exp_q.push_back(ref_eval(int'($signed(in_x))));
            cyc_q.push_back(cyc);
         end
         if (cfg_we && !busy && cfg_fld <= 3'd4) begin
            if (cfg_fld == 3'd4) mbp[cfg_seg] = int'($signed(cfg_data));
            else mc[cfg_seg][cfg_fld] = int'($signed(cfg_data));
         end
         prev_stall = out_valid && !out_ready;
         prev_y = int'($signed(out_y));
         last_acc = in_valid && in_ready;
      end
   end

   task automatic send(input int x);
      in_valid = 1'b1;
      in_x = DW'(x);
      @(negedge clk);
      while (!last_acc) @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      in_valid = 1'b0;
      while (busy || exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic cfg(input int seg, input int fld, input int val);
      while (busy) @(negedge clk);
      cfg_we = 1'b1;
      cfg_seg = 4'(seg);
      cfg_fld = 3'(fld);
      cfg_data = DW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

   initial begin
      for (int s = 0; s < SN; s++) begin
         mbp[s] = 0;
         for (int k = 0; k < 4; k++) mc[s][k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle state and empty table
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 in_ready", int'(in_ready), 1);
      send(16'sh1234);
      drain();
      chk("R1 zero table result", last_y, 0);

      // R2/R5: probe table, each segment returns a distinct constant
      for (int s = 0; s < SN; s++) begin
         cfg(s, 4, -28000 + s * 3500);
         cfg(s, 0, s * 256 - 2048);
      end
      cfg(3, 5, 16'sh7fff);
      cfg(3, 7, 16'sh1111);
      for (int s = 0; s < SN; s++) begin
         send(mbp[s]);
         drain();
         chk("R5 on start point", last_y, s * 256 - 2048);
         send(mbp[s] - 1);
         drain();
         chk("R5 one below start point", last_y, (s == 0 ? 0 : s - 1) * 256 - 2048);
      end
      send(-32768);
      drain();
      chk("R5 below first segment", last_y, -2048);
      send(mbp[3] + 5);
      drain();
      chk("R2 unused field codes ignored", last_y, 3 * 256 - 2048);

      // R6/R8: random cubic tables, unstalled stream
      for (int s = 0; s < SN; s++) begin
         cfg(s, 4, -30000 + s * 4000 + int'($urandom_range(0, 999)));
         cfg(s, 0, int'($urandom_range(0, 16383)) - 8192);
         cfg(s, 1, int'($urandom_range(0, 4095)) - 2048);
         cfg(s, 2, int'($urandom_range(0, 511)) - 256);
         cfg(s, 3, int'($urandom_range(0, 63)) - 32);
      end
      lat_en = 1'b1;
      for (int n = 0; n < 300; n++) send(int'($urandom_range(0, 65535)) - 32768);
      for (int s = 0; s < SN; s++) begin
         send(mbp[s]);
         send(mbp[s] - 1);
         send(mbp[s] + 1);
      end
      send(32767);
      send(-32768);
      drain();
      lat_en = 1'b0;

      // R7: clip at both ends
      cfg(15, 0, 16'sh7000);
      cfg(15, 1, 16'sh7fff);
      cfg(15, 2, 0);
      cfg(15, 3, 0);
      cfg(14, 0, -16'sh7000);
      cfg(14, 1, -32768);
      cfg(14, 2, 0);
      cfg(14, 3, 0);
      send(32767);
      drain();
      chk("R7 clip high", last_y, 32767);
      send(mbp[15] - 1);
      drain();
      chk("R7 clip low", last_y, -32768);

      // R9/R8: random output stalls, order kept
      fork
         begin
            for (int n = 0; n < 120; n++) send(int'($urandom_range(0, 65535)) - 32768);
         end
         begin
            repeat (400) begin
               @(negedge clk);
               out_ready = 1'($urandom_range(0, 1));
            end
            out_ready = 1'b1;
         end
      join
      drain();

      // R3/R4: write slipped in while operands are in flight
      send(mbp[5] + 100);
      send(mbp[5] + 200);
      send(mbp[5] + 300);
      chk("R3 busy during write", int'(busy), 1);
      cfg_we = 1'b1;
      cfg_seg = 4'd5;
      cfg_fld = 3'd0;
      cfg_data = 16'sh4000;
      in_valid = 1'b1;
      in_x = DW'(mbp[5] + 50);
      @(negedge clk);
      chk("R4 operand not taken during write", int'(last_acc), 0);
      cfg_we = 1'b0;
      @(negedge clk);
      while (!last_acc) @(negedge clk);
      in_valid = 1'b0;
      drain();
      send(mbp[5] + 400);
      drain();
      chk("R3 table unchanged", last_y, ref_eval(mbp[5] + 400));

      // R10/R4: busy span and a held result
      chk("R10 idle", int'(busy), 0);
      out_ready = 1'b0;
      send(1000);
      chk("R10 busy after accept", int'(busy), 1);
      repeat (10) @(negedge clk);
      chk("R9 result waiting", int'(out_valid), 1);
      chk("R4 blocked by held result", int'(in_ready), 0);
      chk("R10 busy while held", int'(busy), 1);
      out_ready = 1'b1;
      @(negedge clk);
      chk("R10 idle after take", int'(busy), 0);
      drain();

      report();
      $finish;
   end

endmodule